// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block keeps a small, fully associative set of segment descriptors and maps an effective address (EA) to the descriptor that covers it. Each slot holds two 64-bit words. The segment-tag word carries the segment number in its upper bits and a valid flag at bit 27. The descriptor word carries a 2-bit size field in bits 63:62, where 00 means a 256 MB segment and 01 means a 1 TB segment. It also carries a page-size code made of bits 8, 5 and 4, plus key and virtual-segment bits that are stored without being interpreted.

A dedicated lookup port translates one EA per cycle and returns a registered hit flag, slot index and descriptor. A command port takes one operation per cycle. The operations are:

- a find by EA;
- a checked write to a numbered slot;
- an indexed read of either word;
- invalidation of the segment that covers an EA, with a local or a global variant;
- invalidation of every slot except slot 0.

Each command answers one cycle later with data, an error flag, and one-cycle requests to flush local or global translation caches.

Top module: `slb_array`

## Requirements
- R1: After reset every slot reads zero and every lookup misses. A miss on the lookup port gives `lk_hit`=0, `lk_idx`=0 and `lk_vsid`=0.
- R2: A slot whose size field is 00 hits when its tag word equals {EA[63:28], valid=1, 27 zero bits}. The lookup port registers the result and presents hit, index and descriptor in the cycle after `lk_ea` is applied.
- R3: A slot whose size field is 01 hits when its tag word equals {EA[63:40], 12 zero bits, valid=1, 27 zero bits}. A 1 TB slot whose stored bits 39:28 are nonzero therefore never hits.
- R4: When several slots hit, the lowest-numbered slot is selected, both on the lookup port and for the command port.
- R5: Opcode 1 (write) takes its slot from `op_addr[11:0]`, stores {`op_addr[63:12]`, 12 zero bits} as the tag word and `op_data` as the descriptor. It answers in the next cycle with `rsp_valid`=1, `rsp_err`=0 and `rsp_data`=0.
- R6: A write is rejected, with `rsp_err`=1 and no slot changed, in any of these cases:
  - the slot is at or beyond ENTRIES;
  - any of `op_addr[26:12]` is set;
  - `op_data[63:62]` is 10 or 11;
  - `op_data[63:62]` is 01 while SUPPORT_1T is 0.
- R7: A write is also rejected unless the page-size code {`op_data[8]`, `op_data[5]`, `op_data[4]`} equals one of the configured codes. The default codes are 000, 101, 100 and 110.
- R8: Opcodes 2 and 3 return the tag word and the descriptor word, respectively, of slot `op_addr[11:0]`. Upper operand bits are ignored. A slot at or beyond ENTRIES gives `rsp_err`=1 and data 0.
- R9: Opcode 0 (find) with `mode64`=1 returns the descriptor of the selected slot, or all ones on a miss. With `mode64`=0 it gives `rsp_err`=1 and data 0.
- R10: Opcodes 4 and 5 clear the valid bit of the selected slot for `op_addr`. Opcode 4 then pulses `flush_local` and opcode 5 pulses `flush_global`, each with the response. A miss changes nothing and raises no flush.
- R11: Opcode 6 clears the valid bit of slots 1 to ENTRIES-1 and leaves slot 0 untouched. It pulses `flush_local` only when one of those slots was valid beforehand.
- R12: Opcode 7 is undefined. It gives `rsp_err`=1 and changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Command present this cycle |
| op_code | input | 3 | Command opcode (0 to 7) |
| op_addr | input | 64 | EA or slot operand |
| op_data | input | 64 | Descriptor word for writes |
| mode64 | input | 1 | 64-bit mode, required by find |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 64 | Response data |
| rsp_err | output | 1 | Illegal-operation error |
| flush_local | output | 1 | Local translation-cache flush request |
| flush_global | output | 1 | Global translation-cache flush request |
| lk_ea | input | 64 | EA for the lookup port |
| lk_hit | output | 1 | Registered lookup hit |
| lk_idx | output | IDX_W | Registered index of the selected slot |
| lk_vsid | output | 64 | Registered descriptor of the selected slot |

## Verification
The hardest state to reach from the ports is two valid slots that cover the same segment. A checked write never refuses a duplicate, so the stimulus deliberately stores the same 256 MB tag in slots 3 and 9. It then shows that slot 3 wins, that a local invalidate exposes slot 9, and that a global invalidate removes slot 9 in turn. A second hard case is a 1 TB slot with stray segment bits, which can be written but must never hit. It is created on purpose and probed under both masks.

// File: rtl/slb_array.sv
module slb_array #(
  parameter int ENTRIES = 32,
  parameter bit SUPPORT_1T = 1'b1,
  parameter int NUM_PS = 4,
  parameter logic [NUM_PS*3-1:0] PS_CODES = 12'b110_100_101_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [2:0]          op_code,
  input  logic [63:0]         op_addr,
  input  logic [63:0]         op_data,
  input  logic                mode64,
  output logic                rsp_valid,
  output logic [63:0]         rsp_data,
  output logic                rsp_err,
  output logic                flush_local,
  output logic                flush_global,
  input  logic [63:0]         lk_ea,
  output logic                lk_hit,
  output logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] lk_idx,
  output logic [63:0]         lk_vsid
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [12:0] ENT13 = 13'(ENTRIES);
  localparam int VBIT = 27;
  localparam logic [2:0] OP_FIND = 3'd0, OP_WR = 3'd1, OP_RDE = 3'd2, OP_RDV = 3'd3,
                         OP_INVL = 3'd4, OP_INVG = 3'd5, OP_INVA = 3'd6;

  logic [63:0] tag_q [ENTRIES];
  logic [63:0] dsc_q [ENTRIES];
  logic [ENTRIES-1:0] lk_hv, op_hv;
  logic lk_any, op_any, hi_valid, ps_ok;
  logic [IDX_W-1:0] lk_sel, op_sel;

  function automatic logic seg_match(input logic [63:0] t, input logic [63:0] d,
                                     input logic [63:0] a);
    return ((t == {a[63:28], 1'b1, 27'b0}) && (d[63:62] == 2'b00)) ||
           ((t == {a[63:40], 12'b0, 1'b1, 27'b0}) && (d[63:62] == 2'b01));
  endfunction

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_hv[g] = seg_match(tag_q[g], dsc_q[g], lk_ea);
    assign op_hv[g] = seg_match(tag_q[g], dsc_q[g], op_addr);
  end

  always_comb begin
    lk_any = 1'b0; lk_sel = '0; op_any = 1'b0; op_sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_hv[i]) begin lk_any = 1'b1; lk_sel = IDX_W'(i); end
      if (op_hv[i]) begin op_any = 1'b1; op_sel = IDX_W'(i); end
    end
  end

  always_comb begin
    hi_valid = 1'b0;
    for (int i = 1; i < ENTRIES; i++) hi_valid = hi_valid | tag_q[i][VBIT];
  end

  always_comb begin
    ps_ok = 1'b0;
    for (int i = 0; i < NUM_PS; i++)
      if ({op_data[8], op_data[5:4]} == PS_CODES[i*3 +: 3]) ps_ok = 1'b1;
  end

  wire [11:0] slot = op_addr[11:0];
  wire slot_ok = {1'b0, slot} < ENT13;
  wire [IDX_W-1:0] sidx = slot[IDX_W-1:0];
  wire size_bad = op_data[63] | (op_data[62] & !SUPPORT_1T);
  wire wr_ok = slot_ok & ~(|op_addr[26:12]) & ~size_bad & ps_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin tag_q[i] <= '0; dsc_q[i] <= '0; end
      rsp_valid <= 1'b0; rsp_data <= '0; rsp_err <= 1'b0;
      flush_local <= 1'b0; flush_global <= 1'b0;
      lk_hit <= 1'b0; lk_idx <= '0; lk_vsid <= '0;
    end else begin
      rsp_valid <= op_valid;
      rsp_data <= '0; rsp_err <= 1'b0;
      flush_local <= 1'b0; flush_global <= 1'b0;
      lk_hit <= lk_any;
      lk_idx <= lk_sel;
      lk_vsid <= lk_any ? dsc_q[lk_sel] : '0;
      if (op_valid) begin
        case (op_code)
          OP_FIND:
            if (!mode64) rsp_err <= 1'b1;
            else rsp_data <= op_any ? dsc_q[op_sel] : '1;
          OP_WR:
            if (wr_ok) begin
              tag_q[sidx] <= {op_addr[63:12], 12'b0};
              dsc_q[sidx] <= op_data;
            end else rsp_err <= 1'b1;
          OP_RDE:
            if (slot_ok) rsp_data <= tag_q[sidx]; else rsp_err <= 1'b1;
          OP_RDV:
            if (slot_ok) rsp_data <= dsc_q[sidx]; else rsp_err <= 1'b1;
          OP_INVL, OP_INVG:
            if (op_any) begin
              tag_q[op_sel][VBIT] <= 1'b0;
              flush_local <= (op_code == OP_INVL);
              flush_global <= (op_code == OP_INVG);
            end
          OP_INVA: begin
            for (int i = 1; i < ENTRIES; i++) tag_q[i][VBIT] <= 1'b0;
            flush_local <= hi_valid;
          end
          default: rsp_err <= 1'b1;
        endcase
      end
    end
  end
endmodule

module slb_array_props #(parameter int ENTRIES = 32) (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op_code,
  input logic [63:0] op_addr,
  input logic        mode64,
  input logic        rsp_valid,
  input logic [63:0] rsp_data,
  input logic        rsp_err,
  input logic        flush_local,
  input logic        flush_global
);
  p_rsp_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> rsp_valid);
  p_rsp_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !rsp_valid);
  p_flush_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_local && flush_global));
  p_local_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_local |-> ($past(op_valid) && ($past(op_code) == 3'd4 || $past(op_code) == 3'd6)));
  p_global_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_global |-> ($past(op_valid) && $past(op_code) == 3'd5));
  p_find_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd0 && !mode64) |=> (rsp_err && rsp_data == 64'd0));
  p_err_noflush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (!flush_local && !flush_global));
  p_badslot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 3'd2 || op_code == 3'd3) && ({1'b0, op_addr[11:0]} >= 13'(ENTRIES)))
    |=> rsp_err);
  p_undef_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd7) |=> rsp_err);
endmodule

bind slb_array slb_array_props #(.ENTRIES(ENTRIES)) u_props (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr),
  .mode64(mode64), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
  .flush_local(flush_local), .flush_global(flush_global));

// File: tb/slb_array_test.sv
module slb_array_test;
  localparam int CLK_P = 10;
  localparam int IDX_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, mode64 = 1'b1;
  logic [2:0] op_code = '0;
  logic [63:0] op_addr = '0, op_data = '0, lk_ea = '0;
  logic rsp_valid, rsp_err, flush_local, flush_global, lk_hit;
  logic [63:0] rsp_data, lk_vsid;
  logic [IDX_W-1:0] lk_idx;

  int compared = 0, mismatched = 0;
  logic [66:0] exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  slb_array uut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .op_data(op_data), .mode64(mode64), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .flush_local(flush_local),
    .flush_global(flush_global), .lk_ea(lk_ea), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_vsid(lk_vsid));

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL unexpected response: got data=%h err=%b exp none", rsp_data, rsp_err);
      end else begin
        logic [66:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rsp_data, rsp_err, flush_local, flush_global} !== e) begin
          mismatched++;
          $display("FAIL %s: got data=%h err=%b fl=%b fg=%b exp data=%h err=%b fl=%b fg=%b",
                   t, rsp_data, rsp_err, flush_local, flush_global, e[66:3], e[2], e[1], e[0]);
        end
      end
    end
  end

  task automatic do_op(input logic [2:0] c, input logic [63:0] a, input logic [63:0] d,
                       input logic m, input logic [63:0] ed, input logic ee,
                       input logic efl, input logic efg, input string t);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; op_addr = a; op_data = d; mode64 = m;
    exp_q.push_back({ed, ee, efl, efg});
    tag_q.push_back(t);
  endtask

  task automatic look(input logic [63:0] ea, input logic eh, input logic [IDX_W-1:0] ei,
                      input logic [63:0] ev, input string t);
    @(negedge clk);
    op_valid = 1'b0; lk_ea = ea;
    @(negedge clk);
    compared++;
    if ({lk_hit, lk_idx, lk_vsid} !== {eh, ei, ev}) begin
      mismatched++;
      $display("FAIL %s: got hit=%b idx=%0d vsid=%h exp hit=%b idx=%0d vsid=%h",
               t, lk_hit, lk_idx, lk_vsid, eh, ei, ev);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hung run exp completion");
      finish_run();
    end
  end

  localparam logic [63:0] V1 = 64'h0000_0012_3450_0C00;
  localparam logic [63:0] V2 = 64'h4000_0000_0ABC_0110;
  localparam logic [63:0] V3 = 64'h4000_0000_0000_0000;
  localparam logic [63:0] V4 = 64'h0000_0000_0000_0100;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    look(64'h0, 1'b0, 0, 64'h0, "R1 lookup after reset");
    do_op(3'd2, 64'h0, 64'h0, 1, 64'h0, 0, 0, 0, "R1 tag slot0 zero");
    do_op(3'd3, 64'h1F, 64'h0, 1, 64'h0, 0, 0, 0, "R1 desc slot31 zero");
    // R5 write and readback
    do_op(3'd1, 64'h0000_0000_5800_0003, V1, 1, 64'h0, 0, 0, 0, "R5 write slot3");
    do_op(3'd2, 64'h3, 64'h0, 1, 64'h0000_0000_5800_0000, 0, 0, 0, "R5 tag readback");
    do_op(3'd3, 64'h3, 64'h0, 1, V1, 0, 0, 0, "R5 desc readback");
    do_op(3'd2, 64'hFFFF_0000_0000_0003, 64'h0, 1, 64'h0000_0000_5800_0000, 0, 0, 0, "R8 upper bits ignored");
    // R2 256M match
    look(64'h0000_0000_5ABC_DEF0, 1'b1, 3, V1, "R2 256M hit");
    look(64'h0000_0000_6000_0000, 1'b0, 0, 64'h0, "R2 256M miss");
    // R9 find
    do_op(3'd0, 64'h0000_0000_5123_4567, 64'h0, 1, V1, 0, 0, 0, "R9 find hit");
    do_op(3'd0, 64'h0000_0000_7000_0000, 64'h0, 1, '1, 0, 0, 0, "R9 find miss all ones");
    do_op(3'd0, 64'h0000_0000_5123_4567, 64'h0, 0, 64'h0, 1, 0, 0, "R9 find not 64-bit");
    // R3 1T match
    do_op(3'd1, 64'h0000_0200_0800_0005, V2, 1, 64'h0, 0, 0, 0, "R3 write 1T slot5");
    do_op(3'd1, 64'h0000_0300_1800_0006, V3, 1, 64'h0, 0, 0, 0, "R3 write 1T stray slot6");
    look(64'h0000_02FF_FFFF_1234, 1'b1, 5, V2, "R3 1T hit");
    look(64'h0000_0300_1000_0000, 1'b0, 0, 64'h0, "R3 stray 1T never hits");
    // R4 priority
    do_op(3'd1, 64'h0000_0000_5800_0009, V4, 1, 64'h0, 0, 0, 0, "R4 duplicate slot9");
    look(64'h0000_0000_5000_0000, 1'b1, 3, V1, "R4 lowest slot wins");
    // R6 / R7 rejected writes
    do_op(3'd1, 64'h0000_0000_5800_0020, V1, 1, 64'h0, 1, 0, 0, "R6 slot out of range");
    do_op(3'd1, 64'h0000_0000_5800_1002, V1, 1, 64'h0, 1, 0, 0, "R6 reserved tag bit");
    do_op(3'd1, 64'h0000_0000_5800_0002, 64'h8000_0000_0000_0000, 1, 64'h0, 1, 0, 0, "R6 size 10");
    do_op(3'd1, 64'h0000_0000_5800_0002, 64'hC000_0000_0000_0000, 1, 64'h0, 1, 0, 0, "R6 size 11");
    do_op(3'd1, 64'h0000_0000_5800_0002, 64'h0000_0000_0000_0010, 1, 64'h0, 1, 0, 0, "R7 page code 001");
    do_op(3'd1, 64'h0000_0000_5800_0002, 64'h0000_0000_0000_0130, 1, 64'h0, 1, 0, 0, "R7 page code 111");
    do_op(3'd2, 64'h2, 64'h0, 1, 64'h0, 0, 0, 0, "R6 slot2 tag unchanged");
    do_op(3'd3, 64'h2, 64'h0, 1, 64'h0, 0, 0, 0, "R7 slot2 desc unchanged");
    // R8 read out of range
    do_op(3'd3, 64'h20, 64'h0, 1, 64'h0, 1, 0, 0, "R8 desc read out of range");
    do_op(3'd2, 64'hFFF, 64'h0, 1, 64'h0, 1, 0, 0, "R8 tag read out of range");
    // R10 invalidate by address
    do_op(3'd4, 64'h0000_0000_5000_0000, 64'h0, 1, 64'h0, 0, 1, 0, "R10 local invalidate");
    look(64'h0000_0000_5000_0000, 1'b1, 9, V4, "R10 next duplicate exposed");
    do_op(3'd5, 64'h0000_0000_5000_0000, 64'h0, 1, 64'h0, 0, 0, 1, "R10 global invalidate");
    look(64'h0000_0000_5000_0000, 1'b0, 0, 64'h0, "R10 segment gone");
    do_op(3'd4, 64'h0000_0000_5000_0000, 64'h0, 1, 64'h0, 0, 0, 0, "R10 miss no flush");
    // R11 invalidate all
    do_op(3'd1, 64'h0000_0000_1800_0000, 64'h0, 1, 64'h0, 0, 0, 0, "R11 write slot0");
    do_op(3'd6, 64'h0, 64'h0, 1, 64'h0, 0, 1, 0, "R11 invalidate all flush");
    look(64'h0000_0000_1000_0000, 1'b1, 0, 64'h0, "R11 slot0 kept");
    look(64'h0000_02FF_FFFF_1234, 1'b0, 0, 64'h0, "R11 1T slot cleared");
    do_op(3'd2, 64'h5, 64'h0, 1, 64'h0000_0200_0000_0000, 0, 0, 0, "R11 slot5 valid bit cleared");
    do_op(3'd6, 64'h0, 64'h0, 1, 64'h0, 0, 0, 0, "R11 nothing valid no flush");
    // R12 undefined opcode
    do_op(3'd7, 64'h0000_0000_1000_0000, 64'h0, 1, 64'h0, 1, 0, 0, "R12 undefined opcode");
    look(64'h0000_0000_1000_0000, 1'b1, 0, 64'h0, "R12 state unchanged");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL missing responses: got %0d pending exp 0", exp_q.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule